// File: doc/BRIEF.md
# Cell Link Sequencing and Retransmission Controller

This block keeps a full-duplex, cell-framed link reliable. Every outgoing cell carries a 16-bit sequence number and the number this end expects next from its peer. Each received header brings the peer's own sequence number, its expectation of ours (an acknowledgement), and a copy of the peer's error counters. The controller numbers new cells and tracks the next incoming number. It releases transmit slots as acknowledgements arrive and discards any cell that arrives out of order. When no acknowledgement progress is seen for a set number of cell periods, it rewinds and resends every unacknowledged cell in order (go-back retransmission).

Cell storage, the Reed-Solomon decoder and the 8b/10b decoder live outside the block and appear only as status pulses. The framing logic gives one `cell_tick` pulse per cell slot. On each tick the controller picks what to send in the next slot: a resent cell, a new cell, or nothing. Six saturating link-health counters are kept locally and placed in every outgoing header. The peer's copies are latched from each usable received header, so the local processor can read both sets.

Top module: `cell_link_seq_ctrl`

## Requirements
- R1: After reset, all sequence state is zero: next new number, oldest unacknowledged number, transmit pointer and expected incoming number. All local and peer counters are zero, and `tx_send` and `rx_accept` are low.
- R2: On a `cell_tick` with no resend pending and `new_cell_avail` high, a new cell is sent only while fewer than WINDOW cells are unacknowledged. The cycle after the tick, `tx_send`=1, `tx_retx`=0 and `tx_seq` is the new cell's number. With WINDOW cells outstanding, nothing is sent.
- R3: All sequence numbers are 16 bits and wrap from 0xFFFF to 0x0000 without disturbing transmission, acknowledgement or reception.
- R4: A usable received cell whose number equals the expected one is accepted. `rx_accept` pulses the next cycle, and `tx_ack` (the expected number placed in outgoing headers) advances by one.
- R5: A usable received cell whose number differs from the expected one is discarded. `tx_ack` is unchanged, `rx_accept` stays low, and the out-of-sequence counter increments.
- R6: The acknowledgement in a usable header frees all cells below it, when it lies beyond the oldest unacknowledged number and no further than the next new number. An advance of more than one cell increments the multiple-acknowledge counter. An acknowledgement equal to the oldest number, or beyond the next new number, has no effect.
- R7: Count the `cell_tick`s that arrive while cells are outstanding and no acknowledgement advances. On the TIMEOUT_CELLS-th such tick, the transmit pointer `tx_ptr` rewinds to the oldest unacknowledged number, the timeout counter increments, the count restarts, and no cell is sent in that slot. Later ticks resend from there with `tx_retx`=1. An acknowledgement advance restarts the count and wins over an expiring tick in the same cycle.
- R8: If an acknowledgement advances past the transmit pointer during a resend, the pointer jumps to the acknowledged number, so acknowledged cells are not resent.
- R9: A cell flagged uncorrectable is counted and otherwise ignored. It changes neither the expected number, the acknowledgement state nor the peer counters.
- R10: Each `rx_line_err` pulse increments the line-decode counter, and each `rx_fix_err` pulse increments the corrected-error counter, independently of cell reception.
- R11: Every counter is CNT_BITS wide (16) and holds at its maximum value instead of wrapping.
- R12: Each usable received header latches `rx_peer_cnt` into `peer_cnt`. Counter updates and peer latches appear one cycle after the event.
- R13: Counter k occupies bits [16k+15:16k] of `loc_cnt`, `rx_peer_cnt` and `peer_cnt`, in this order: 0 out-of-sequence, 1 multiple-acknowledge, 2 timeout, 3 line-decode error, 4 corrected error, 5 uncorrectable error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_tick | input | 1 | One pulse per outgoing cell slot |
| new_cell_avail | input | 1 | A new user cell is waiting to be sent |
| rx_valid | input | 1 | A received cell header is present this cycle |
| rx_seq | input | 16 | Sequence number of the received cell |
| rx_ack | input | 16 | Peer's next expected number (acknowledgement) |
| rx_uncorr | input | 1 | Received cell has uncorrectable errors |
| rx_line_err | input | 1 | Line decoder error pulse |
| rx_fix_err | input | 1 | Corrected-error pulse from the ECC decoder |
| rx_peer_cnt | input | 96 | Peer's counters from the received header |
| tx_send | output | 1 | A cell is sent in the slot following the tick |
| tx_retx | output | 1 | The sent cell is a resend |
| tx_seq | output | 16 | Sequence number of the sent cell |
| tx_ack | output | 16 | Expected incoming number for outgoing headers |
| tx_ptr | output | 16 | Transmit (retransmit) pointer |
| rx_accept | output | 1 | Received cell accepted in order |
| loc_cnt | output | 96 | Local counters, packed per R13 |
| peer_cnt | output | 96 | Latched peer counters, packed per R13 |

## Verification
The bench drives the timer to expiry while cells are outstanding, then sends an acknowledgement that jumps past the rewound pointer in the middle of a resend. A design that skipped the jump would resend cells already acknowledged. It also sends acknowledgements that are stale, zero-advance or beyond the next new number, which a loose range check would wrongly accept. A long run keeps the link busy through more than 65,536 cells and holds an error pulse high throughout. Wrong modulo arithmetic then shows up as a stalled window or a wrong `tx_ack`, and a wrapping counter returns to a small value instead of holding at 0xFFFF. Uncorrectable cells carrying plausible acknowledgements and peer values are mixed in at random, and a design that acted on them would move the window or the peer copies.

// File: rtl/cls_pkg.sv
package cls_pkg;
  parameter int unsigned SEQ_BITS = 16;
  parameter int unsigned CNT_BITS = 16;
  localparam int unsigned NUM_CNT = 6;
  localparam int unsigned PACK_W  = NUM_CNT * CNT_BITS;

  // counter slots; peers decode this order from the header
  localparam int unsigned CI_OOS    = 0;
  localparam int unsigned CI_MULTI  = 1;
  localparam int unsigned CI_TMO    = 2;
  localparam int unsigned CI_LINE   = 3;
  localparam int unsigned CI_FIX    = 4;
  localparam int unsigned CI_UNCORR = 5;

  typedef logic [SEQ_BITS-1:0] seq_t;
  typedef logic [CNT_BITS-1:0] cnt_t;

  // modular distance from earlier to later
  function automatic seq_t seq_gap(seq_t later, seq_t earlier);
    return later - earlier;
  endfunction

  // an acknowledgement is usable when it moves forward and stays inside the sent range
  function automatic logic ack_covers(seq_t gap, seq_t inflight);
    return (gap != '0) && (gap <= inflight);
  endfunction

  function automatic cnt_t cnt_bump(cnt_t c, logic ev);
    if (ev && (c != '1)) return c + 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/cls_tx_window.sv
module cls_tx_window
  import cls_pkg::*;
#(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic avail,
  input  logic fire,
  input  logic good_hdr,
  input  seq_t ack_val,
  output seq_t base_q,
  output seq_t ptr_q,
  output seq_t inflight,
  output logic ack_adv,
  output logic ack_multi,
  output logic send_q,
  output logic retx_q,
  output seq_t seq_q
);
  seq_t next_q;
  seq_t ack_gap, ptr_step, ptr_d;
  logic pend_retx, room, do_retx, do_new;

  always_comb begin
    inflight  = seq_gap(next_q, base_q);
    ack_gap   = seq_gap(ack_val, base_q);
    ack_adv   = good_hdr && ack_covers(ack_gap, inflight);
    ack_multi = ack_adv && (ack_gap > seq_t'(1));
    room      = inflight < seq_t'(WINDOW);
    pend_retx = ptr_q != next_q;
    do_retx   = tick && !fire && pend_retx;
    do_new    = tick && !fire && !pend_retx && avail && room;
    ptr_step  = (do_retx || do_new) ? ptr_q + 1'b1 : ptr_q;
    if (fire)
      ptr_d = base_q;
    else if (ack_adv && (seq_gap(ptr_step, base_q) < ack_gap))
      ptr_d = ack_val;
    else
      ptr_d = ptr_step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      next_q <= '0;
      ptr_q  <= '0;
      send_q <= 1'b0;
      retx_q <= 1'b0;
      seq_q  <= '0;
    end else begin
      ptr_q  <= ptr_d;
      if (do_new) next_q <= next_q + 1'b1;
      if (ack_adv) base_q <= ack_val;
      send_q <= do_retx || do_new;
      retx_q <= do_retx;
      if (do_retx || do_new) seq_q <= ptr_q;
    end
  end
endmodule

// File: rtl/cls_retx_timer.sv
module cls_retx_timer #(
  parameter int unsigned TIMEOUT_CELLS = 20,
  localparam int unsigned TW = $clog2(TIMEOUT_CELLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic ack_adv,
  output logic fire
);
  logic [TW-1:0] cnt_q;

  assign fire = tick && busy && !ack_adv && (cnt_q == TW'(TIMEOUT_CELLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (ack_adv || fire)
      cnt_q <= '0;
    else if (tick && busy)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cls_rx_order.sv
module cls_rx_order
  import cls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic rx_uncorr,
  input  seq_t rx_seq,
  output logic good_hdr,
  output logic oos_evt,
  output seq_t exp_q,
  output logic accept_q
);
  logic in_order;

  always_comb begin
    good_hdr = rx_valid && !rx_uncorr;
    in_order = good_hdr && (rx_seq == exp_q);
    oos_evt  = good_hdr && (rx_seq != exp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q    <= '0;
      accept_q <= 1'b0;
    end else begin
      accept_q <= in_order;
      if (in_order) exp_q <= exp_q + 1'b1;
    end
  end
endmodule

// File: rtl/cls_err_bank.sv
module cls_err_bank
  import cls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CNT-1:0] events,
  input  logic              good_hdr,
  input  logic [PACK_W-1:0] peer_in,
  output logic [PACK_W-1:0] loc_out,
  output logic [PACK_W-1:0] peer_out
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    cnt_t loc_q, peer_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loc_q  <= '0;
        peer_q <= '0;
      end else begin
        loc_q <= cnt_bump(loc_q, events[k]);
        if (good_hdr) peer_q <= peer_in[k*CNT_BITS +: CNT_BITS];
      end
    end
    assign loc_out[k*CNT_BITS +: CNT_BITS]  = loc_q;
    assign peer_out[k*CNT_BITS +: CNT_BITS] = peer_q;
  end
endmodule

// File: rtl/cell_link_seq_ctrl.sv
module cell_link_seq_ctrl
  import cls_pkg::*;
#(
  parameter int unsigned WINDOW        = 16,
  parameter int unsigned TIMEOUT_CELLS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_tick,
  input  logic              new_cell_avail,
  input  logic              rx_valid,
  input  logic [SEQ_BITS-1:0] rx_seq,
  input  logic [SEQ_BITS-1:0] rx_ack,
  input  logic              rx_uncorr,
  input  logic              rx_line_err,
  input  logic              rx_fix_err,
  input  logic [PACK_W-1:0] rx_peer_cnt,
  output logic              tx_send,
  output logic              tx_retx,
  output logic [SEQ_BITS-1:0] tx_seq,
  output logic [SEQ_BITS-1:0] tx_ack,
  output logic [SEQ_BITS-1:0] tx_ptr,
  output logic              rx_accept,
  output logic [PACK_W-1:0] loc_cnt,
  output logic [PACK_W-1:0] peer_cnt
);
  // internal events, named for the checker
  logic good_hdr, oos_evt, ack_adv, ack_multi, tmo_fire;
  seq_t base_w, inflight_w;
  logic [NUM_CNT-1:0] cnt_ev;

  cls_rx_order u_rx (
    .clk, .rst_n, .rx_valid, .rx_uncorr, .rx_seq,
    .good_hdr, .oos_evt, .exp_q(tx_ack), .accept_q(rx_accept)
  );

  cls_tx_window #(.WINDOW(WINDOW)) u_win (
    .clk, .rst_n, .tick(cell_tick), .avail(new_cell_avail), .fire(tmo_fire),
    .good_hdr, .ack_val(rx_ack), .base_q(base_w), .ptr_q(tx_ptr),
    .inflight(inflight_w), .ack_adv, .ack_multi,
    .send_q(tx_send), .retx_q(tx_retx), .seq_q(tx_seq)
  );

  cls_retx_timer #(.TIMEOUT_CELLS(TIMEOUT_CELLS)) u_tmr (
    .clk, .rst_n, .tick(cell_tick), .busy(inflight_w != '0),
    .ack_adv, .fire(tmo_fire)
  );

  always_comb begin
    cnt_ev            = '0;
    cnt_ev[CI_OOS]    = oos_evt;
    cnt_ev[CI_MULTI]  = ack_multi;
    cnt_ev[CI_TMO]    = tmo_fire;
    cnt_ev[CI_LINE]   = rx_line_err;
    cnt_ev[CI_FIX]    = rx_fix_err;
    cnt_ev[CI_UNCORR] = rx_valid && rx_uncorr;
  end

  cls_err_bank u_cnt (
    .clk, .rst_n, .events(cnt_ev), .good_hdr, .peer_in(rx_peer_cnt),
    .loc_out(loc_cnt), .peer_out(peer_cnt)
  );
endmodule

// File: rtl/cls_checker.sv
module cls_checker
  import cls_pkg::*;
#(
  parameter int unsigned WINDOW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_uncorr,
  input logic              tx_send,
  input seq_t              tx_ack,
  input seq_t              tx_ptr,
  input logic              rx_accept,
  input logic [PACK_W-1:0] loc_cnt,
  input seq_t              base_w,
  input seq_t              inflight_w,
  input logic              oos_evt,
  input logic              ack_multi,
  input logic              tmo_fire
);
  cnt_t multi_c;
  assign multi_c = loc_cnt[CI_MULTI*CNT_BITS +: CNT_BITS];

  p_window_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_w <= seq_t'(WINDOW));

  p_accept_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> (tx_ack == seq_t'($past(tx_ack) + 1'b1)));

  p_oos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oos_evt |=> ($stable(tx_ack) && !rx_accept));

  p_multi_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_multi |=> ((multi_c == cnt_t'($past(multi_c) + 1'b1)) || (multi_c == '1)));

  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> ((tx_ptr == $past(base_w)) && !tx_send));

  p_uncorr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_uncorr) |=> ($stable(tx_ack) && !rx_accept));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_sat
    p_hold_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(loc_cnt[k*CNT_BITS +: CNT_BITS]) == '1) |->
        (loc_cnt[k*CNT_BITS +: CNT_BITS] == '1));
  end
endmodule

bind cell_link_seq_ctrl cls_checker #(.WINDOW(WINDOW)) u_chk (
  .clk, .rst_n, .rx_valid, .rx_uncorr, .tx_send, .tx_ack, .tx_ptr,
  .rx_accept, .loc_cnt, .base_w, .inflight_w, .oos_evt, .ack_multi, .tmo_fire
);

// File: tb/tb_cell_link_seq_ctrl.sv
module tb_cell_link_seq_ctrl;
  import cls_pkg::*;
  localparam int WIN = 16;
  localparam int TMO = 20;
  localparam int NC  = 6;
  localparam int CB  = 16;
  localparam int PW  = NC * CB;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_tick = 0, i_avail = 0, i_valid = 0, i_uncorr = 0, i_line = 0, i_fix = 0;
  logic [15:0] i_seq = '0, i_ack = '0;
  logic [PW-1:0] i_peer = '0;
  logic tx_send, tx_retx, rx_accept;
  logic [15:0] tx_seq, tx_ack, tx_ptr;
  logic [PW-1:0] loc_cnt, peer_cnt;

  always #4 clk = ~clk;

  cell_link_seq_ctrl #(.WINDOW(WIN), .TIMEOUT_CELLS(TMO)) dut (
    .clk, .rst_n, .cell_tick(i_tick), .new_cell_avail(i_avail),
    .rx_valid(i_valid), .rx_seq(i_seq), .rx_ack(i_ack), .rx_uncorr(i_uncorr),
    .rx_line_err(i_line), .rx_fix_err(i_fix), .rx_peer_cnt(i_peer),
    .tx_send, .tx_retx, .tx_seq, .tx_ack, .tx_ptr, .rx_accept, .loc_cnt, .peer_cnt
  );

  // reference state, written from the requirements
  logic [15:0] m_base, m_next, m_ptr, m_exp, m_seq;
  int m_timer;
  logic m_send, m_retx, m_acc, m_fired;
  int m_cnt [NC];
  logic [PW-1:0] m_peer;
  int n_chk = 0, n_fail = 0;
  longint sends_total = 0, accepts_total = 0;
  string cnt_tag [NC] = '{"R5", "R6", "R7", "R10", "R10", "R9"};

  task automatic chk(string tag, string what, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int bump(int c, logic ev);
    return (ev && c < CMAX) ? c + 1 : c;
  endfunction

  task automatic model_reset();
    m_base = 0; m_next = 0; m_ptr = 0; m_exp = 0; m_seq = 0; m_timer = 0;
    m_send = 0; m_retx = 0; m_acc = 0; m_fired = 0; m_peer = '0;
    for (int k = 0; k < NC; k++) m_cnt[k] = 0;
  endtask

  task automatic model_edge();
    logic good, adv, tmo, rt, nw;
    logic [15:0] infl, gap, p;
    good = i_valid && !i_uncorr;
    infl = m_next - m_base;
    gap  = i_ack - m_base;
    adv  = good && gap != 0 && gap <= infl;
    tmo  = i_tick && infl != 0 && !adv && m_timer == TMO - 1;
    rt   = i_tick && !tmo && m_ptr != m_next;
    nw   = i_tick && !tmo && m_ptr == m_next && i_avail && infl < 16'(WIN);
    m_send = rt || nw; m_retx = rt; m_fired = tmo;
    if (m_send) begin m_seq = m_ptr; sends_total++; end
    p = m_send ? m_ptr + 1 : m_ptr;
    if (tmo) p = m_base;
    else if (adv && 16'(p - m_base) < gap) p = i_ack;
    m_ptr = p;
    if (nw) m_next = m_next + 1;
    m_cnt[1] = bump(m_cnt[1], adv && gap > 1);
    if (adv) m_base = i_ack;
    if (adv || tmo) m_timer = 0;
    else if (i_tick && infl != 0) m_timer++;
    m_acc = good && i_seq == m_exp;
    m_cnt[0] = bump(m_cnt[0], good && i_seq != m_exp);
    if (m_acc) begin m_exp = m_exp + 1; accepts_total++; end
    m_cnt[2] = bump(m_cnt[2], tmo);
    m_cnt[3] = bump(m_cnt[3], i_line);
    m_cnt[4] = bump(m_cnt[4], i_fix);
    m_cnt[5] = bump(m_cnt[5], i_valid && i_uncorr);
    if (good) m_peer = i_peer;
  endtask

  task automatic compare();
    chk("R2", "tx_send", tx_send, m_send);
    if (m_send) begin
      chk("R2", "tx_seq", tx_seq, m_seq);
      chk("R7", "tx_retx", tx_retx, m_retx);
    end
    chk("R4", "tx_ack", tx_ack, m_exp);
    chk("R4", "rx_accept", rx_accept, m_acc);
    chk("R7", "tx_ptr", tx_ptr, m_ptr);
    for (int k = 0; k < NC; k++)
      chk(cnt_tag[k], $sformatf("loc_cnt[%0d]", k), loc_cnt[k*CB +: CB], m_cnt[k]);
    chk("R12", "peer_cnt", (peer_cnt == m_peer) ? 1 : 0, 1);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    i_tick = 0; i_avail = 0; i_valid = 0; i_uncorr = 0; i_line = 0; i_fix = 0;
  endtask

  task automatic rand_peer();
    for (int k = 0; k < NC; k++) i_peer[k*CB +: CB] = 16'($urandom);
  endtask

  initial begin
    #(8 * 180000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [PW-1:0] peer_save;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tx_send", tx_send, 0);
    chk("R1", "rx_accept", rx_accept, 0);
    chk("R1", "tx_ack", tx_ack, 0);
    chk("R1", "tx_ptr", tx_ptr, 0);
    chk("R1", "loc_cnt", (loc_cnt == '0) ? 1 : 0, 1);
    chk("R1", "peer_cnt", (peer_cnt == '0) ? 1 : 0, 1);
    rst_n = 1'b1;

    // send four new cells, then starve acks until the timer expires (R7)
    i_tick = 1; i_avail = 1;
    repeat (4) step();
    chk("R2", "next seq after four sends", tx_seq, 3);
    i_avail = 0;
    for (int n = 0; n < 40; n++) begin
      step();
      if (m_fired) break;
    end
    chk("R7", "rewind ptr", tx_ptr, 0);
    chk("R7", "timeout count", loc_cnt[2*CB +: CB], 1);
    chk("R7", "no send on expiry", tx_send, 0);
    step();
    chk("R7", "resend flag", tx_retx, 1);
    chk("R7", "resend seq", tx_seq, 0);
    // R8: ack 3 while pointer sits at 1
    idle(); i_valid = 1; i_seq = 0; i_ack = 3; rand_peer();
    step();
    chk("R8", "pointer jumps to ack", tx_ptr, 3);
    chk("R6", "multi ack count", loc_cnt[1*CB +: CB], 1);
    // R6: ack beyond sent range is ignored
    i_seq = 1; i_ack = 9;
    step();
    chk("R6", "bogus ack keeps ptr", tx_ptr, 3);
    chk("R6", "bogus ack no count", loc_cnt[1*CB +: CB], 1);
    idle(); i_tick = 1;
    step();
    chk("R7", "resend remaining cell", tx_seq, 3);
    idle(); i_valid = 1; i_seq = 2; i_ack = 4;
    step();
    // R5 / R13: out of sequence
    i_seq = 16'd8; i_ack = 4;
    step();
    chk("R5", "tx_ack held", tx_ack, 3);
    chk("R13", "slot 0 is out-of-sequence", loc_cnt[0 +: CB], 1);
    // R9: uncorrectable cell with a plausible header
    peer_save = peer_cnt;
    i_uncorr = 1; i_seq = 3; i_ack = 4; rand_peer();
    step();
    chk("R9", "tx_ack unchanged", tx_ack, 3);
    chk("R9", "uncorr slot 5", loc_cnt[5*CB +: CB], 1);
    chk("R9", "peer untouched", (peer_cnt == peer_save) ? 1 : 0, 1);
    // R10
    idle(); i_line = 1; i_fix = 1;
    step();
    chk("R10", "line slot 3", loc_cnt[3*CB +: CB], 1);
    chk("R10", "fix slot 4", loc_cnt[4*CB +: CB], 1);
    // R2: window fills at WIN outstanding
    idle(); i_tick = 1; i_avail = 1;
    repeat (WIN) step();
    step();
    chk("R2", "window full blocks send", tx_send, 0);
    idle(); i_valid = 1; i_seq = m_exp; i_ack = m_next; rand_peer();
    step();
    chk("R6", "bulk ack counted", loc_cnt[1*CB +: CB], 2);

    // constrained random phase
    for (int cyc = 0; cyc < 6000; cyc++) begin
      logic quiet;
      logic [15:0] infl;
      quiet = ((cyc / 200) % 3) == 2;
      infl = m_next - m_base;
      i_tick  = ($urandom % 3) == 0;
      i_avail = ($urandom % 4) != 0;
      i_valid = !quiet && (($urandom % 3) == 0);
      i_uncorr = ($urandom % 10) == 0;
      i_seq = (($urandom % 8) == 0) ? m_exp + 16'(1 + $urandom % 3) : m_exp;
      i_ack = m_base + 16'($urandom % (32'(infl) + 2));
      i_line = ($urandom % 7) == 0;
      i_fix  = ($urandom % 9) == 0;
      rand_peer();
      step();
    end

    // long busy run: sequence wrap (R3) and counter saturation (R11)
    idle();
    for (int cyc = 0; cyc < 70000; cyc++) begin
      i_tick = 1; i_avail = 1; i_valid = 1; i_uncorr = 0;
      i_seq = m_exp; i_ack = m_next; i_line = 1; i_fix = 0;
      step();
    end
    chk("R3", "sends passed wrap", (sends_total > 65536) ? 1 : 0, 1);
    chk("R3", "tx_ack after wrap", tx_ack, accepts_total % 65536);
    chk("R3", "sending continues after wrap", tx_send, 1);
    chk("R11", "line counter saturated", loc_cnt[3*CB +: CB], CMAX);
    idle();
    step();
    chk("R11", "saturated counter holds", loc_cnt[3*CB +: CB], CMAX);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule